// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as seven packed-BCD byte registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A clock-enable running at 32.768 kHz feeds a binary prescaler. Each time the prescaler wraps, it emits a one-cycle second pulse, and that pulse starts a carry walk through the registers. A host port can write any register and read any register back. Hours are kept in either 24-hour or 12-hour (AM/PM) form, chosen by a bit inside the hour byte.

The carry walk is a small state machine. In `ST_IDLE`, a second pulse advances the seconds. If the seconds wrap from 59, the machine moves to `ST_MIN` and advances the minutes on the next cycle. A minute wrap moves it to `ST_HOUR`. A midnight crossing moves it to `ST_DAY`, which steps both the weekday and the date. A month-end date moves it to `ST_MON`, and a December wrap moves it to `ST_YEAR`. Every state returns to `ST_IDLE` when there is no further carry, and `ST_YEAR` always returns there. So a full year rollover takes six cycles. This is far shorter than the gap between second pulses.

Register map (address: register, stored bits): 0 seconds (bit 7 halt, bits 6:0 BCD), 1 minutes (6:0), 2 hours (bit 6 selects 12-hour, bit 5 is PM or the 20s digit, 4:0), 3 weekday (2:0), 4 date (5:0), 5 month (4:0), 6 year (7:0). Address 7 holds nothing.

Top module: `rtcc_calendar`

## Requirements
- R1: The seconds and minutes count in BCD from 00 to 59. The wrap 59→00 carries into the next register.
- R2: While seconds bit 7 is 1, the seconds register and the prescaler hold and no second pulse is produced. When the bit is 0, counting resumes.
- R3: With hour bit 6 = 0, hours count 00–23 in BCD, with bits 5:4 as the tens digit. The wrap 23→00 advances the date and the weekday.
- R4: With hour bit 6 = 1, bit 5 is PM and bits 4:0 hold 01–12. The sequence is 11 AM→12 PM→01 PM and 11 PM→12 AM→01 AM. Only the 11 PM→12 AM step advances the date.
- R5: The weekday (address 3) steps at each midnight and wraps from 07 to 01.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. A wrap advances the month.
- R7: February ends at 29 when the BCD year is divisible by 4 (00 counts as leap) and at 28 otherwise.
- R8: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R9: A second pulse occurs once every 2^DIV_BITS cycles that have the oscillator enable high. Any write to the seconds register restarts this count from zero, and no pulse occurs in the cycle of the write.
- R10: Bits that hold no field read as 0. The masks are: minutes bit 7, hours bit 7, weekday bits 7:3, date bits 7:6 and month bits 7:5. Address 7 reads 0x00.
- R11: A host write to a register takes effect in place of a carry step on that same register in the same cycle.
- R12: After reset, the registers read: seconds 00 (running), minutes 00, hours 00 in 24-hour form, weekday 01, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for the read |
| rd_data | output | 8 | Read data (combinational) |
| sec_tick | output | 1 | One-cycle second pulse |

## Verification
The assertions assume that the registers hold legal BCD values for their fields. They also assume the prescaler is at least 3 bits wide, so that no second pulse can arrive while a carry walk is still in progress. The stimulus writes only legal times and dates, with the date kept within the length of its month. It halts the clock while it loads the registers and then releases the clock with the final seconds write, so no carry lands in a register that is only half loaded. The bench runs the prescaler with 4 bits. It samples each result a fixed eight cycles after the expected pulse, and the longest carry walk finishes within that window.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MIN  = 3'd1,
        ST_HOUR = 3'd2,
        ST_DAY  = 3'd3,
        ST_MON  = 3'd4,
        ST_YEAR = 3'd5
    } rtcc_state_e;

    localparam int unsigned NUM_REGS = 7;

    localparam logic [2:0] A_SEC  = 3'd0;
    localparam logic [2:0] A_MIN  = 3'd1;
    localparam logic [2:0] A_HOUR = 3'd2;
    localparam logic [2:0] A_WDAY = 3'd3;
    localparam logic [2:0] A_DATE = 3'd4;
    localparam logic [2:0] A_MON  = 3'd5;
    localparam logic [2:0] A_YEAR = 3'd6;

    localparam logic [7:0] M_SEC  = 8'hFF;
    localparam logic [7:0] M_MIN  = 8'h7F;
    localparam logic [7:0] M_HOUR = 8'h7F;
    localparam logic [7:0] M_WDAY = 8'h07;
    localparam logic [7:0] M_DATE = 8'h3F;
    localparam logic [7:0] M_MON  = 8'h1F;
    localparam logic [7:0] M_YEAR = 8'hFF;

    // Add one to a packed two-digit BCD value (no wrap at 99).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

endpackage

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
    parameter int unsigned DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam logic [DIV_BITS-1:0] CNT_MAX = {DIV_BITS{1'b1}};

    logic [DIV_BITS-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clear)          cnt_q <= '0;
        else if (osc_en && run)  cnt_q <= cnt_q + 1'b1;
    end

    assign tick = osc_en && run && !clear && (cnt_q == CNT_MAX);

endmodule

// File: rtl/rtcc_month_len.sv
module rtcc_month_len (
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [5:0] last_date
);
    logic leap;

    // A BCD year is a multiple of four when an even tens digit meets
    // units 0/4/8, or an odd tens digit meets units 2/6.
    always_comb begin
        if (year[4]) leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        else         leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) ||
                            (year[3:0] == 4'd8);
    end

    always_comb begin
        unique case (month)
            5'h02:                      last_date = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
            default:                    last_date = 6'h31;
        endcase
    end

endmodule

// File: rtl/rtcc_hour_step.sv
module rtcc_hour_step
    import rtcc_pkg::*;
(
    input  logic [6:0] hour_in,
    output logic [6:0] hour_out,
    output logic       day_carry
);
    logic [7:0] inc24;
    logic [7:0] inc12;

    assign inc24 = bcd_inc({2'b00, hour_in[5:0]});
    assign inc12 = bcd_inc({3'b000, hour_in[4:0]});

    always_comb begin
        hour_out  = hour_in;
        day_carry = 1'b0;
        if (hour_in[6]) begin
            if (hour_in[4:0] == 5'h11) begin
                hour_out  = {1'b1, ~hour_in[5], 5'h12};
                day_carry = hour_in[5];
            end else if (hour_in[4:0] == 5'h12) begin
                hour_out  = {1'b1, hour_in[5], 5'h01};
            end else begin
                hour_out  = {1'b1, hour_in[5], inc12[4:0]};
            end
        end else begin
            if (hour_in[5:0] == 6'h23) begin
                hour_out  = 7'h00;
                day_carry = 1'b1;
            end else begin
                hour_out  = {1'b0, inc24[5:0]};
            end
        end
    end

endmodule

// File: rtl/rtcc_calendar.sv
module rtcc_calendar
    import rtcc_pkg::*;
#(
    parameter int unsigned DIV_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       sec_tick
);
    rtcc_state_e state_q, state_d;

    logic [7:0] sec_q, min_q, hour_q, wday_q, date_q, month_q, year_q;
    logic [NUM_REGS-1:0] wr_hit;
    logic [6:0] hour_next;
    logic       hour_carry;
    logic [5:0] last_date;
    logic [7:0] sec_inc, min_inc, date_inc, mon_inc, year_inc;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign wr_hit[i] = wr_en && (wr_addr == 3'(i));
    end

    rtcc_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (osc_en),
        .run    (!sec_q[7]),
        .clear  (wr_hit[A_SEC]),
        .tick   (sec_tick)
    );

    rtcc_hour_step u_hour (
        .hour_in   (hour_q[6:0]),
        .hour_out  (hour_next),
        .day_carry (hour_carry)
    );

    rtcc_month_len u_mlen (
        .month     (month_q[4:0]),
        .year      (year_q),
        .last_date (last_date)
    );

    assign sec_inc  = bcd_inc({1'b0, sec_q[6:0]});
    assign min_inc  = bcd_inc({1'b0, min_q[6:0]});
    assign date_inc = bcd_inc({2'b00, date_q[5:0]});
    assign mon_inc  = bcd_inc({3'b000, month_q[4:0]});
    assign year_inc = bcd_inc(year_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Carry walk transitions
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = (sec_tick && sec_q[6:0] == 7'h59) ? ST_MIN  : ST_IDLE;
            ST_MIN:  state_d = (min_q[6:0] == 7'h59)             ? ST_HOUR : ST_IDLE;
            ST_HOUR: state_d = hour_carry                        ? ST_DAY  : ST_IDLE;
            ST_DAY:  state_d = (date_q[5:0] == last_date)        ? ST_MON  : ST_IDLE;
            ST_MON:  state_d = (month_q[4:0] == 5'h12)           ? ST_YEAR : ST_IDLE;
            ST_YEAR: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Register updates: host write first, then the step owned by the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= 8'h00;
            min_q   <= 8'h00;
            hour_q  <= 8'h00;
            wday_q  <= 8'h01;
            date_q  <= 8'h01;
            month_q <= 8'h01;
            year_q  <= 8'h00;
        end else begin
            if (wr_hit[A_SEC])
                sec_q <= wr_data & M_SEC;
            else if (sec_tick && state_q == ST_IDLE)
                sec_q <= {sec_q[7], (sec_q[6:0] == 7'h59) ? 7'h00 : sec_inc[6:0]};

            if (wr_hit[A_MIN])
                min_q <= wr_data & M_MIN;
            else if (state_q == ST_MIN)
                min_q <= (min_q[6:0] == 7'h59) ? 8'h00 : min_inc;

            if (wr_hit[A_HOUR])
                hour_q <= wr_data & M_HOUR;
            else if (state_q == ST_HOUR)
                hour_q <= {1'b0, hour_next};

            if (wr_hit[A_WDAY])
                wday_q <= wr_data & M_WDAY;
            else if (state_q == ST_DAY)
                wday_q <= (wday_q[2:0] == 3'd7) ? 8'h01 : {5'b0, wday_q[2:0] + 3'd1};

            if (wr_hit[A_DATE])
                date_q <= wr_data & M_DATE;
            else if (state_q == ST_DAY)
                date_q <= (date_q[5:0] == last_date) ? 8'h01 : date_inc;

            if (wr_hit[A_MON])
                month_q <= wr_data & M_MON;
            else if (state_q == ST_MON)
                month_q <= (month_q[4:0] == 5'h12) ? 8'h01 : mon_inc;

            if (wr_hit[A_YEAR])
                year_q <= wr_data & M_YEAR;
            else if (state_q == ST_YEAR)
                year_q <= (year_q == 8'h99) ? 8'h00 : year_inc;
        end
    end

    // Read port
    always_comb begin
        unique case (rd_addr)
            A_SEC:   rd_data = sec_q;
            A_MIN:   rd_data = min_q;
            A_HOUR:  rd_data = hour_q;
            A_WDAY:  rd_data = wday_q;
            A_DATE:  rd_data = date_q;
            A_MON:   rd_data = month_q;
            A_YEAR:  rd_data = year_q;
            default: rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtcc_calendar_chk.sv
module rtcc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       sec_tick,
    input logic       busy,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q,
    input logic [7:0] wday_q,
    input logic [7:0] date_q,
    input logic [7:0] month_q
);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !(wr_en && wr_addr == 3'd0)) |=> $stable(sec_q));

    // R2
    halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q[7] |-> !sec_tick);

    // R9
    clear_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> !sec_tick);

    // R9
    tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> !busy);

    // R1
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00));

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1) |=> (min_q == {1'b0, $past(wr_data[6:0])}));

    // R10
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (min_q[7] == 1'b0 && hour_q[7] == 1'b0 && wday_q[7:3] == 5'd0 &&
         date_q[7:6] == 2'd0 && month_q[7:5] == 3'd0));

endmodule

bind rtcc_calendar rtcc_calendar_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sec_tick (sec_tick),
    .busy     (state_q != rtcc_pkg::ST_IDLE),
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hour_q   (hour_q),
    .wday_q   (wday_q),
    .date_q   (date_q),
    .month_q  (month_q)
);

// File: tb/rtcc_calendar_test.sv
`timescale 1ns/1ps
module rtcc_calendar_test;

    localparam int DIVB = 4;
    localparam int PER  = 1 << DIVB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       sec_tick;

    int checks = 0;
    int fails  = 0;

    int m_sec, m_min, m_hr, m_mode12, m_wday, m_date, m_mon, m_yr;

    always #2 clk = ~clk;

    rtcc_calendar #(.DIV_BITS(DIVB)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sec_tick (sec_tick)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte();
        int h12;
        if (m_mode12 == 0) return to_bcd(m_hr);
        h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
        return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
    endfunction

    task automatic step_model();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
                    m_date++;
                    if (m_date > days_in(m_mon, m_yr)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_yr = (m_yr + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic set_model(input int s, input int mi, input int h, input int md,
                             input int wd, input int dt, input int mo, input int y);
        m_sec = s; m_min = mi; m_hr = h; m_mode12 = md;
        m_wday = wd; m_date = dt; m_mon = mo; m_yr = y;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string what);
        rd_addr = a;
        #0.3;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", what, rd_data, exp);
        end
    endtask

    // Halt, load every field, then release with the seconds write.
    task automatic load_model();
        wr_reg(3'd0, 8'h80);
        wr_reg(3'd1, to_bcd(m_min));
        wr_reg(3'd2, hour_byte());
        wr_reg(3'd3, to_bcd(m_wday));
        wr_reg(3'd4, to_bcd(m_date));
        wr_reg(3'd5, to_bcd(m_mon));
        wr_reg(3'd6, to_bcd(m_yr));
        wr_reg(3'd0, to_bcd(m_sec));
    endtask

    task automatic check_all(input string tag);
        rd_chk(3'd0, to_bcd(m_sec),  {tag, " seconds"});
        rd_chk(3'd1, to_bcd(m_min),  {tag, " minutes"});
        rd_chk(3'd2, hour_byte(),    {tag, " hours"});
        rd_chk(3'd3, to_bcd(m_wday), {tag, " weekday"});
        rd_chk(3'd4, to_bcd(m_date), {tag, " date"});
        rd_chk(3'd5, to_bcd(m_mon),  {tag, " month"});
        rd_chk(3'd6, to_bcd(m_yr),   {tag, " year"});
        @(negedge clk);
    endtask

    task automatic run_case(input int k, input string tag);
        load_model();
        repeat (k * PER + 8) @(negedge clk);
        for (int i = 0; i < k; i++) step_model();
        check_all(tag);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240229));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        set_model(0, 0, 0, 0, 1, 1, 1, 0);
        check_all("R12 reset");
        rd_chk(3'd7, 8'h00, "R10 empty address");

        // Directed carries
        set_model(59, 59, 23, 0, 7, 31, 12, 99);
        run_case(1, "R3 R5 R8 year rollover");
        set_model(59, 59, 23, 0, 3, 28, 2, 24);
        run_case(1, "R7 leap Feb 28");
        set_model(59, 59, 23, 0, 3, 28, 2, 23);
        run_case(1, "R7 common Feb 28");
        set_model(59, 59, 23, 0, 2, 29, 2, 0);
        run_case(1, "R7 Feb 29 year 00");
        set_model(59, 59, 23, 0, 4, 30, 4, 15);
        run_case(1, "R6 April end");
        set_model(59, 59, 23, 0, 4, 30, 5, 15);
        run_case(1, "R6 May 30");
        set_model(59, 59, 11, 1, 1, 10, 6, 30);
        run_case(1, "R4 11 AM to noon");
        set_model(59, 59, 23, 1, 6, 10, 6, 30);
        run_case(1, "R4 R5 11 PM to midnight");
        set_model(59, 59, 12, 1, 6, 10, 6, 30);
        run_case(1, "R4 12 PM to 1 PM");
        set_model(57, 41, 8, 0, 2, 5, 3, 11);
        run_case(3, "R1 minute carry");

        // R2 halt
        set_model(5, 20, 10, 0, 2, 5, 3, 11);
        load_model();
        wr_reg(3'd0, 8'h85);
        repeat (3 * PER) @(negedge clk);
        rd_chk(3'd0, 8'h85, "R2 halted seconds");
        rd_chk(3'd1, 8'h20, "R2 halted minutes");
        @(negedge clk);
        wr_reg(3'd0, 8'h05);
        repeat (PER + 8) @(negedge clk);
        rd_chk(3'd0, 8'h06, "R2 resumed seconds");
        @(negedge clk);

        // R9 seconds write restarts the prescaler
        set_model(10, 20, 10, 0, 2, 5, 3, 11);
        load_model();
        repeat (12) @(negedge clk);
        wr_reg(3'd0, 8'h20);
        repeat (12) @(negedge clk);
        rd_chk(3'd0, 8'h20, "R9 no pulse after restart");
        @(negedge clk);
        repeat (5) @(negedge clk);
        rd_chk(3'd0, 8'h21, "R9 pulse after full period");
        @(negedge clk);

        // R10 unused bits
        wr_reg(3'd0, 8'h80);
        wr_reg(3'd1, 8'hA5);
        wr_reg(3'd2, 8'h95);
        wr_reg(3'd3, 8'hFD);
        wr_reg(3'd4, 8'hD4);
        wr_reg(3'd5, 8'hE1);
        rd_chk(3'd1, 8'h25, "R10 minutes mask");
        rd_chk(3'd2, 8'h15, "R10 hours mask");
        rd_chk(3'd3, 8'h05, "R10 weekday mask");
        rd_chk(3'd4, 8'h14, "R10 date mask");
        rd_chk(3'd5, 8'h01, "R10 month mask");
        @(negedge clk);

        // R11 host write meets the minute carry step
        set_model(59, 5, 14, 0, 2, 5, 3, 11);
        load_model();
        repeat (PER) @(negedge clk);
        wr_reg(3'd1, 8'h30);
        repeat (6) @(negedge clk);
        rd_chk(3'd1, 8'h30, "R11 write beats carry");
        rd_chk(3'd0, 8'h00, "R11 seconds wrapped");
        rd_chk(3'd2, 8'h14, "R11 hours untouched");
        @(negedge clk);

        // Random legal times
        for (int it = 0; it < 24; it++) begin
            int s, mo, y, k;
            s  = ($urandom % 2 == 0) ? 55 + int'($urandom % 5) : int'($urandom % 60);
            mo = 1 + int'($urandom % 12);
            y  = int'($urandom % 100);
            k  = 1 + int'($urandom % 3);
            set_model(s, ($urandom % 2 == 0) ? 59 : int'($urandom % 60),
                      ($urandom % 2 == 0) ? 23 : int'($urandom % 24),
                      int'($urandom % 2), 1 + int'($urandom % 7),
                      ($urandom % 2 == 0) ? days_in(mo, y) : 1 + int'($urandom % 28),
                      mo, y);
            run_case(k, "random R1 R3 R4 R5 R6 R8");
        end

        finish_up();
    end

endmodule